// File: doc/BRIEF.md
# Semaphore-Driven Descriptor Channel Controller

The block runs up to four independent work channels that share one memory port and one downstream processing engine. Software loads a channel's command pointer with the byte address of an eight-word descriptor and then adds to the channel's semaphore. An enabled channel with a nonzero semaphore, a nonzero pointer and a clear error code competes for service. The winning channel reads its descriptor in one uninterrupted burst of eight single-word beats. It presents the control words, source, destination and size to the engine, waits for the engine to finish, and writes a status word back into the descriptor's last word.

Each descriptor carries its own flags. Bit 1 of the first control word asks for the semaphore to drop by one on completion, and bit 0 asks for the channel's bit in the global interrupt status to be set. After a good completion the pointer takes the link word, so a chain keeps running while the count stays nonzero and the link is not zero. A failed descriptor read or an engine error freezes the channel with a nonzero code until software clears it.

Top module: `sdc_ctrl`

## Requirements
- R1: After reset every readable register (global status, enable mask, each channel's pointer, count and error code) reads zero, `irq` is low and no memory beat is requested.
- R2: A write to a channel's count register (channel base + 0x10) adds the low byte of the data to the count, saturating at 255; the count reads back at the same offset. A channel whose pointer is zero does not start.
- R3: A started channel reads eight words at ascending addresses pointer, pointer+4, ... pointer+28. Each beat holds its request, address and direction until `mem_ack`, and no other channel's beat is interleaved.
- R4: While `eng_valid` is high the engine sees the channel number, control word 0 (word 1), control word 1 (word 2), source (word 3), destination (word 4) and size (word 5), steady until `eng_done`.
- R5: The engine result is written to pointer+28: bit 0 is set on success and bits [23:16] carry the error code, with all other bits zero.
- R6: On completion, control bit 1 lowers the count by one and control bit 0 sets the channel's bit n of the global status (offset 0x10); `irq` is high while any status bit is set.
- R7: A good completion loads the pointer from word 0. Processing continues while the count is nonzero and the link is nonzero, and a zero link leaves the channel idle.
- R8: The enable mask at offset 0x20 (bit n for channel n) reads back as written. A channel whose bit is zero does not start even with a nonzero count.
- R9: Writing ones to offset 0x18 clears the matching global status bits and leaves the others set.
- R10: A read error on any descriptor beat sets the channel's code (channel base + 0x20) to 0x01 and always sets its status bit. A nonzero `eng_err` becomes the code and is written back. On either error the count and pointer stay as they were and the channel does not start again until ones written at channel base + 0x28 clear the code.
- R11: Channels are served round robin: after channel k, the next served is the first ready channel after k, in wrapping order.
- R12: A count increment from software and a completion decrement that land in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Beat complete |
| mem_err | input | 1 | Read beat failed, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| eng_valid | output | 1 | Work item presented |
| eng_chan | output | 2 | Channel of the work item |
| eng_ctrl0 | output | 32 | Control word 0 |
| eng_ctrl1 | output | 32 | Control word 1 |
| eng_src | output | 32 | Source address |
| eng_dst | output | 32 | Destination address |
| eng_size | output | 32 | Byte count |
| eng_done | input | 1 | Engine finished the item |
| eng_err | input | 8 | Engine error code, valid with eng_done, zero for success |
| irq | output | 1 | Any global status bit set |

## Verification
Two things can hit the same channel's count in one cycle: software adding to it and the completion of that channel's descriptor taking one away. The bench holds the write-back beat of a descriptor with the decrement flag, then writes the count register so that its strobe is sampled on the same edge as the releasing acknowledge. A correct design leaves the count at its value before the pair. Losing either update shows up as a count one too high or one too low when the register is read back.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN, S_WB} sdc_st_e;

    // global register offsets (reg_addr[5:0] with reg_addr[11:6] == 0)
    localparam logic [5:0] OFF_G_STAT = 6'h10;
    localparam logic [5:0] OFF_G_CLR  = 6'h18;
    localparam logic [5:0] OFF_G_EN   = 6'h20;
    // channel register offsets inside a 0x40 window above 0x100
    localparam logic [5:0] OFF_C_PTR  = 6'h00;
    localparam logic [5:0] OFF_C_SEMA = 6'h10;
    localparam logic [5:0] OFF_C_STAT = 6'h20;
    localparam logic [5:0] OFF_C_CLR  = 6'h28;

    localparam int W_NEXT = 0;
    localparam int W_CTL0 = 1;
    localparam int W_CTL1 = 2;
    localparam int W_SRC  = 3;
    localparam int W_DST  = 4;
    localparam int W_SIZE = 5;
    localparam logic [2:0] W_LAST = 3'd7;

    localparam int CTL_IRQ = 0;
    localparam int CTL_DEC = 1;
    localparam logic [7:0] ERR_FETCH = 8'h01;
endpackage

// File: rtl/sdc_rr_pick.sv
module sdc_rr_pick #(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    input  logic [CHW-1:0] last,
    output logic           any,
    output logic [CHW-1:0] gnt
);
    always_comb begin
        any = 1'b0;
        gnt = last;
        for (int i = 1; i <= NCH; i++) begin
            if (!any && req[(int'(last) + i) % NCH]) begin
                any = 1'b1;
                gnt = CHW'((int'(last) + i) % NCH);
            end
        end
    end
endmodule

// File: rtl/sdc_chan.sv
module sdc_chan #(
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_ptr,
    input  logic              wr_sema,
    input  logic              wr_clr,
    input  logic [31:0]       wdata,
    input  logic              done,
    input  logic [31:0]       done_next,
    input  logic              done_dec,
    input  logic [7:0]        done_err,
    output logic              ready,
    output logic [31:0]       ptr,
    output logic [SEMA_W-1:0] sema,
    output logic [7:0]        err
);
    localparam int SUM_W = SEMA_W + 2;
    localparam logic [SUM_W-1:0] SEMA_MAX = SUM_W'((1 << SEMA_W) - 1);

    typedef struct packed {
        logic [31:0]       ptr;
        logic [SEMA_W-1:0] sema;
        logic [7:0]        err;
    } chan_t;

    chan_t c_d, c_q;
    logic [SUM_W-1:0] total;
    logic             good;

    always_comb begin
        c_d   = c_q;
        good  = done && (done_err == 8'h00);
        total = SUM_W'(c_q.sema)
              + (wr_sema ? SUM_W'(wdata[SEMA_W-1:0]) : '0)
              - SUM_W'(good && done_dec);
        c_d.sema = (total > SEMA_MAX) ? SEMA_MAX[SEMA_W-1:0] : total[SEMA_W-1:0];
        if (good)
            c_d.ptr = done_next;
        if (wr_ptr)
            c_d.ptr = wdata;
        if (wr_clr)
            c_d.err = c_q.err & ~wdata[7:0];
        if (done && !good)
            c_d.err = done_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ptr   = c_q.ptr;
    assign sema  = c_q.sema;
    assign err   = c_q.err;
    assign ready = en && (c_q.sema != '0) && (c_q.err == 8'h00) && (c_q.ptr != 32'h0);
endmodule

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
    import sdc_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int SEMA_W = 8,
    parameter int RA_W   = 12,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [31:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic            mem_ack,
    input  logic            mem_err,
    input  logic [31:0]     mem_rdata,
    output logic            eng_valid,
    output logic [CHW-1:0]  eng_chan,
    output logic [31:0]     eng_ctrl0,
    output logic [31:0]     eng_ctrl1,
    output logic [31:0]     eng_src,
    output logic [31:0]     eng_dst,
    output logic [31:0]     eng_size,
    input  logic            eng_done,
    input  logic [7:0]      eng_err,
    output logic            irq
);
    typedef struct packed {
        sdc_st_e          st;
        logic [CHW-1:0]   ch;
        logic [CHW-1:0]   last;
        logic [2:0]       beat;
        logic [31:0]      base;
        logic [7:0][31:0] w;
        logic [7:0]       code;
        logic [NCH-1:0]   gstat;
        logic [NCH-1:0]   en;
    } seq_t;

    seq_t r_d, r_q;

    logic [NCH-1:0]             ch_ready, wr_ptr, wr_sema, wr_clr, done_vec;
    logic [NCH-1:0][31:0]       ch_ptr;
    logic [NCH-1:0][SEMA_W-1:0] ch_sema;
    logic [NCH-1:0][7:0]        ch_err;
    logic                       glob_hit, chan_hit, pick_any, start, done, done_irq;
    logic [CHW-1:0]             pick, start_ch;
    logic [1:0]                 sel;
    logic [5:0]                 off;
    logic [7:0]                 done_err;

    assign off      = reg_addr[5:0];
    assign sel      = reg_addr[7:6];
    assign glob_hit = (reg_addr[RA_W-1:6] == '0);
    assign chan_hit = (reg_addr[RA_W-1:8] == (RA_W-8)'(1));

    sdc_rr_pick #(.NCH(NCH)) u_pick (
        .req(ch_ready), .last(r_q.last), .any(pick_any), .gnt(pick)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign wr_ptr[n]   = reg_wr && chan_hit && (sel == 2'(n)) && (off == OFF_C_PTR);
        assign wr_sema[n]  = reg_wr && chan_hit && (sel == 2'(n)) && (off == OFF_C_SEMA);
        assign wr_clr[n]   = reg_wr && chan_hit && (sel == 2'(n)) && (off == OFF_C_CLR);
        assign done_vec[n] = done && (r_q.ch == CHW'(n));
        sdc_chan #(.SEMA_W(SEMA_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .en(r_q.en[n]),
            .wr_ptr(wr_ptr[n]), .wr_sema(wr_sema[n]), .wr_clr(wr_clr[n]), .wdata(reg_wdata),
            .done(done_vec[n]), .done_next(r_q.w[W_NEXT]), .done_dec(r_q.w[W_CTL0][CTL_DEC]),
            .done_err(done_err), .ready(ch_ready[n]), .ptr(ch_ptr[n]),
            .sema(ch_sema[n]), .err(ch_err[n])
        );
    end

    always_comb begin
        r_d      = r_q;
        start    = 1'b0;
        start_ch = pick;
        done     = 1'b0;
        done_err = 8'h00;
        done_irq = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = r_q.base + {27'h0, r_q.beat, 2'b00};
        if (reg_wr && glob_hit && off == OFF_G_CLR)
            r_d.gstat = r_q.gstat & ~reg_wdata[NCH-1:0];
        if (reg_wr && glob_hit && off == OFF_G_EN)
            r_d.en = reg_wdata[NCH-1:0];
        case (r_q.st)
            S_IDLE: if (pick_any) begin
                start     = 1'b1;
                r_d.st    = S_FETCH;
                r_d.ch    = pick;
                r_d.last  = pick;
                r_d.base  = ch_ptr[pick];
                r_d.beat  = 3'd0;
                r_d.code  = 8'h00;
            end
            S_FETCH: begin
                mem_req = 1'b1;
                if (mem_ack && mem_err) begin
                    done     = 1'b1;
                    done_err = ERR_FETCH;
                    done_irq = 1'b1;
                    r_d.st   = S_IDLE;
                end else if (mem_ack) begin
                    r_d.w[r_q.beat] = mem_rdata;
                    r_d.beat        = r_q.beat + 3'd1;
                    if (r_q.beat == W_LAST)
                        r_d.st = S_RUN;
                end
            end
            S_RUN: if (eng_done) begin
                r_d.code = eng_err;
                r_d.st   = S_WB;
            end
            default: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = r_q.base + {27'h0, W_LAST, 2'b00};
                if (mem_ack) begin
                    done     = 1'b1;
                    done_err = r_q.code;
                    done_irq = r_q.w[W_CTL0][CTL_IRQ];
                    r_d.st   = S_IDLE;
                end
            end
        endcase
        if (done && done_irq)
            r_d.gstat[r_q.ch] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = 32'h0;
        if (glob_hit && off == OFF_G_STAT)
            reg_rdata = 32'(r_q.gstat);
        else if (glob_hit && off == OFF_G_EN)
            reg_rdata = 32'(r_q.en);
        else if (chan_hit && int'(sel) < NCH) begin
            case (off)
                OFF_C_PTR:  reg_rdata = ch_ptr[sel[CHW-1:0]];
                OFF_C_SEMA: reg_rdata = 32'(ch_sema[sel[CHW-1:0]]);
                OFF_C_STAT: reg_rdata = 32'(ch_err[sel[CHW-1:0]]);
                default:    reg_rdata = 32'h0;
            endcase
        end
    end

    assign mem_wdata = {8'h00, r_q.code, 15'h0000, (r_q.code == 8'h00)};
    assign eng_valid = (r_q.st == S_RUN);
    assign eng_chan  = r_q.ch;
    assign eng_ctrl0 = r_q.w[W_CTL0];
    assign eng_ctrl1 = r_q.w[W_CTL1];
    assign eng_src   = r_q.w[W_SRC];
    assign eng_dst   = r_q.w[W_DST];
    assign eng_size  = r_q.w[W_SIZE];
    assign irq       = |r_q.gstat;
endmodule

// File: rtl/sdc_chk.sv
module sdc_chk #(
    parameter int NCH    = 4,
    parameter int SEMA_W = 8,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       mem_req,
    input logic                       mem_ack,
    input logic                       mem_we,
    input logic [31:0]                mem_addr,
    input logic                       eng_valid,
    input logic                       eng_done,
    input logic [CHW-1:0]             eng_chan,
    input logic [31:0]                eng_src,
    input logic                       start,
    input logic [CHW-1:0]             start_ch,
    input logic [NCH-1:0]             en,
    input logic [NCH-1:0][SEMA_W-1:0] ch_sema,
    input logic [NCH-1:0][7:0]        ch_err,
    input logic                       done,
    input logic [CHW-1:0]             done_ch,
    input logic [7:0]                 done_err,
    input logic                       done_irq,
    input logic [NCH-1:0]             gstat
);
    p_beat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_eng_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_done) |=> (eng_valid && $stable(eng_chan) && $stable(eng_src)));

    p_start_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (en[start_ch] && ch_sema[start_ch] != '0 && ch_err[start_ch] == 8'h00));

    p_irq_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_irq) |=> gstat[done_ch]);

    p_halt_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err != 8'h00) |=> (ch_err[done_ch] == $past(done_err)));
endmodule

bind sdc_ctrl sdc_chk #(.NCH(NCH), .SEMA_W(SEMA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .eng_valid(eng_valid), .eng_done(eng_done), .eng_chan(eng_chan),
    .eng_src(eng_src), .start(start), .start_ch(start_ch), .en(r_q.en), .ch_sema(ch_sema),
    .ch_err(ch_err), .done(done), .done_ch(r_q.ch), .done_err(done_err),
    .done_irq(done_irq), .gstat(r_q.gstat)
);

// File: tb/sim_sdc_ctrl.sv
`timescale 1ns/1ps
module sim_sdc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        eng_valid, eng_done = 1'b0;
    logic [1:0]  eng_chan;
    logic [31:0] eng_ctrl0, eng_ctrl1, eng_src, eng_dst, eng_size;
    logic [7:0]  eng_err = 8'h00;
    logic        irq;

    always #10 clk = ~clk;

    sdc_ctrl u0 (.*);

    logic [31:0] mem [0:63];
    logic [31:0] fetch_log [0:31];
    logic [1:0]  log_ch [0:15];
    logic [31:0] log_c0 [0:15], log_c1 [0:15], log_src [0:15], log_dst [0:15], log_size [0:15];
    int          n_fetch = 0, n_eng = 0, eng_cnt = 0;
    logic        stall_wr = 1'b0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [7:0]  inj_err = 8'h00;
    int          nchk = 0, nfail = 0;
    logic [31:0] rd;

    // memory: one beat acknowledged every other cycle
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (mem_req && !(mem_we && stall_wr)) begin
            mem_ack = 1'b1;
            if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
            else begin
                mem_rdata = mem[mem_addr[7:2]];
                mem_err   = (mem_addr == err_addr);
                if (n_fetch < 32) fetch_log[n_fetch] = mem_addr;
                n_fetch++;
            end
        end
    end

    // engine: finishes two cycles after the item shows up
    always @(negedge clk) begin
        if (eng_valid && !eng_done) begin
            eng_cnt++;
            if (eng_cnt == 2) begin
                eng_cnt  = 0;
                eng_done = 1'b1;
                eng_err  = inj_err;
                if (n_eng < 16) begin
                    log_ch[n_eng] = eng_chan; log_c0[n_eng] = eng_ctrl0; log_c1[n_eng] = eng_ctrl1;
                    log_src[n_eng] = eng_src; log_dst[n_eng] = eng_dst; log_size[n_eng] = eng_size;
                end
                n_eng++;
            end
        end else begin
            eng_done = 1'b0;
        end
    end

    function automatic logic [11:0] ca(input int n, input int o);
        return 12'(32'h100 + n * 32'h40 + o);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic quiet();
        int q = 0;
        while (q < 12) begin
            @(negedge clk);
            if (mem_req || eng_valid) q = 0; else q++;
        end
    endtask

    task automatic put_desc(input int a, input logic [31:0] nx, input logic [31:0] c0, input logic [31:0] src);
        mem[a/4 + 0] = nx;  mem[a/4 + 1] = c0;  mem[a/4 + 2] = 32'h0000_00A5;
        mem[a/4 + 3] = src; mem[a/4 + 4] = src + 32'h1000; mem[a/4 + 5] = 32'h40;
        mem[a/4 + 6] = 32'h0; mem[a/4 + 7] = 32'hDEAD_BEEF;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rreg(12'h010, rd); chk(rd, 0, "R1 gstat");
        rreg(12'h020, rd); chk(rd, 0, "R1 enable");
        for (int n = 0; n < 4; n++) begin
            rreg(ca(n, 'h00), rd); chk(rd, 0, "R1 ptr");
            rreg(ca(n, 'h10), rd); chk(rd, 0, "R1 sema");
            rreg(ca(n, 'h20), rd); chk(rd, 0, "R1 code");
        end
        chk(32'(irq), 0, "R1 irq");
        chk(32'(mem_req), 0, "R1 mem_req");

        // R8 enable mask readback
        wreg(12'h020, 32'h0F); rreg(12'h020, rd); chk(rd, 32'h0F, "R8 enable readback");

        // R2 count add and saturation, zero pointer never starts
        wreg(ca(1, 'h10), 3); rreg(ca(1, 'h10), rd); chk(rd, 3, "R2 add");
        wreg(ca(1, 'h10), 32'hFF); rreg(ca(1, 'h10), rd); chk(rd, 255, "R2 saturate");
        quiet(); chk(n_fetch, 0, "R2 zero pointer idle");

        // single descriptor on channel 0
        put_desc('h20, 0, 32'h3, 32'h1111);
        wreg(ca(0, 'h00), 32'h20); wreg(ca(0, 'h10), 1); quiet();
        chk(n_fetch, 8, "R3 beat count");
        for (int k = 0; k < 8; k++) chk(fetch_log[k], 32'h20 + 4 * k, "R3 beat address");
        chk(n_eng, 1, "R4 one item");
        chk(32'(log_ch[0]), 0, "R4 chan"); chk(log_c0[0], 3, "R4 ctrl0");
        chk(log_c1[0], 32'hA5, "R4 ctrl1"); chk(log_src[0], 32'h1111, "R4 src");
        chk(log_dst[0], 32'h2111, "R4 dst"); chk(log_size[0], 32'h40, "R4 size");
        chk(mem['h3C / 4], 32'h1, "R5 success word");
        rreg(ca(0, 'h10), rd); chk(rd, 0, "R6 decrement");
        rreg(12'h010, rd); chk(rd, 1, "R6 status bit"); chk(32'(irq), 1, "R6 irq");
        rreg(ca(0, 'h00), rd); chk(rd, 0, "R7 zero link");

        // R9 clear
        wreg(12'h018, 1); rreg(12'h010, rd); chk(rd, 0, "R9 clear"); chk(32'(irq), 0, "R9 irq low");

        // R7 chain on channel 2: no-dec, dec, then stop
        put_desc('h40, 32'h60, 32'h0, 32'h40); put_desc('h60, 32'h80, 32'h2, 32'h60);
        put_desc('h80, 32'h0, 32'h3, 32'h80);
        n_eng = 0;
        wreg(ca(2, 'h00), 32'h40); wreg(ca(2, 'h10), 1); quiet();
        chk(n_eng, 2, "R7 chain length");
        chk(log_src[1], 32'h60, "R7 second link");
        rreg(ca(2, 'h00), rd); chk(rd, 32'h80, "R7 parked pointer");
        rreg(ca(2, 'h10), rd); chk(rd, 0, "R7 count spent");
        rreg(12'h010, rd); chk(rd, 0, "R6 no irq flag");
        wreg(ca(2, 'h10), 1); quiet();
        chk(n_eng, 3, "R7 resume"); rreg(12'h010, rd); chk(rd, 4, "R6 chan2 bit");
        wreg(12'h018, 4);

        // R8 disabled channel holds
        put_desc('hA0, 0, 32'h2, 32'hA0); n_eng = 0;
        wreg(12'h020, 32'h07); wreg(ca(3, 'h00), 32'hA0); wreg(ca(3, 'h10), 1); quiet();
        chk(n_eng, 0, "R8 masked");
        rreg(ca(3, 'h10), rd); chk(rd, 1, "R8 count kept");
        wreg(12'h020, 32'h0F); quiet();
        chk(n_eng, 1, "R8 runs when enabled");

        // R10 engine error on channel 0
        put_desc('hC0, 32'h20, 32'h3, 32'hC0); n_eng = 0; inj_err = 8'h5A;
        wreg(ca(0, 'h00), 32'hC0); wreg(ca(0, 'h10), 2); quiet();
        chk(n_eng, 1, "R10 halted after error");
        chk(mem['hDC / 4], 32'h005A_0000, "R10 error word");
        rreg(ca(0, 'h20), rd); chk(rd, 32'h5A, "R10 code");
        rreg(ca(0, 'h10), rd); chk(rd, 2, "R10 no decrement");
        rreg(ca(0, 'h00), rd); chk(rd, 32'hC0, "R10 pointer kept");
        rreg(12'h010, rd); chk(rd, 1, "R10 irq bit");
        inj_err = 8'h00; put_desc('h20, 0, 32'h2, 32'h20);
        wreg(ca(0, 'h28), 32'hFF); quiet();
        rreg(ca(0, 'h20), rd); chk(rd, 0, "R10 cleared");
        chk(n_eng, 3, "R10 resumes");
        rreg(ca(0, 'h10), rd); chk(rd, 0, "R10 count after resume");

        // R10 fetch error on channel 3 (third beat)
        put_desc('hE0, 0, 32'h2, 32'hE0); err_addr = 32'hE8; n_eng = 0;
        wreg(ca(3, 'h00), 32'hE0); wreg(ca(3, 'h10), 1); quiet();
        chk(n_eng, 0, "R10 no engine on fetch error");
        rreg(ca(3, 'h20), rd); chk(rd, 1, "R10 fetch code");
        rreg(ca(3, 'h10), rd); chk(rd, 1, "R10 fetch count kept");
        rreg(12'h010, rd); chk(rd, 9, "R10 fetch irq bit");
        wreg(12'h018, 8); rreg(12'h010, rd); chk(rd, 1, "R9 partial clear");
        wreg(12'h018, 1); rreg(12'h010, rd); chk(rd, 0, "R9 full clear");
        err_addr = 32'hFFFF_FFFF;
        wreg(ca(3, 'h28), 32'hFF); quiet();
        chk(n_eng, 1, "R10 fetch recovery");

        // R11 round robin, last served was channel 3
        wreg(12'h020, 0);
        put_desc('h20, 32'h40, 32'h2, 32'h20); put_desc('h40, 0, 32'h2, 32'h40);
        put_desc('h60, 0, 32'h2, 32'h60); put_desc('h80, 0, 32'h2, 32'h80);
        wreg(ca(0, 'h00), 32'h20); wreg(ca(0, 'h10), 2);
        wreg(ca(2, 'h00), 32'h60); wreg(ca(2, 'h10), 1);
        wreg(ca(3, 'h00), 32'h80); wreg(ca(3, 'h10), 1);
        n_eng = 0; wreg(12'h020, 32'h0F); quiet();
        chk(n_eng, 4, "R11 item count");
        chk(32'(log_ch[0]), 0, "R11 first"); chk(32'(log_ch[1]), 2, "R11 second");
        chk(32'(log_ch[2]), 3, "R11 third"); chk(32'(log_ch[3]), 0, "R11 fourth");
        chk(log_src[3], 32'h40, "R11 fourth link");

        // R12 same-cycle increment and decrement
        put_desc('hA0, 0, 32'h2, 32'hA0);
        stall_wr = 1'b1;
        wreg(ca(2, 'h00), 32'hA0); wreg(ca(2, 'h10), 1);
        @(negedge clk);
        while (!(mem_req && mem_we)) @(negedge clk);
        @(posedge clk); #3;
        reg_wr = 1'b1; reg_addr = ca(2, 'h10); reg_wdata = 1; stall_wr = 1'b0;
        @(posedge clk); #3;
        reg_wr = 1'b0;
        quiet();
        rreg(ca(2, 'h10), rd); chk(rd, 1, "R12 net count");
        rreg(ca(2, 'h00), rd); chk(rd, 0, "R12 pointer");
        chk(mem['hBC / 4], 32'h1, "R12 write-back");

        finish_run();
    end
endmodule